// File: doc/BRIEF.md
# Secure Device Control Register File

This block is the memory-mapped control bank of a small security token. It sits on a simple word-addressed CPU bus (chip select, write enable, 8-bit word address, 32-bit write and read data). Through it software reads fixed identity constants and a 64-bit unique identity. It drives an RGB LED and two general-purpose outputs, samples two general-purpose inputs, and holds where the loaded application sits and how large it is. It also holds a firmware function pointer, a 256-bit derived secret and two RAM scrambling seeds.

The device starts in firmware mode. Firmware fills in the introspection, pointer and secret registers, then writes the mode-switch register once. From then on the device is in application mode until the next reset. In application mode those registers refuse writes but stay readable. The LED, GPIO outputs and scrambling seeds stay writable in both modes. The seeds can never be read back over the bus; they leave the block only on dedicated ports toward the RAM.

The bus has no stall. Every access completes in its own cycle, so the bus never applies back-pressure. A read issued in one cycle presents its data in the next.

Top module: `secure_ctrl_regs`

## Requirements
- R1: Word addresses 0x00 and 0x01 read the parameter constants NAME0 and NAME1, and 0x02 reads VERSION, in either mode; writes to these addresses change nothing.
- R2: A write of any value to 0x08 while in firmware mode puts the device in application mode. The `app_mode` output then goes to 1 from the next cycle, and 0x08 reads 1 in bit 0. The mode stays set until reset, and further writes to 0x08 have no effect.
- R3: Address 0x09 is readable and writable in both modes. Write data bits [2:0] drive `led[2:0]` with bit 0 blue, bit 1 green and bit 2 red (1 means on), and the register reads back in bits [2:0].
- R4: At address 0x0a, read bits [1:0] show `gpio_in[1:0]` after a two-flop synchronizer: a level present before clock edge k is returned by a read issued at edge k+2. Bits [3:2] are stored from write data bits [3:2], drive `gpio_out[1:0]` and read back; bits [1:0] of a write are ignored.
- R5: Application start (0x0c), application size (0x0d) and the function pointer (0x10) accept writes only in firmware mode and read back in both modes.
- R6: Secret word i (0 to 7) lives at 0x20+i. It accepts writes only in firmware mode and reads back in both modes.
- R7: 0x30 reads UID[63:32] and 0x31 reads UID[31:0] from a parameter constant; writes to these addresses change nothing.
- R8: 0x40 (address scramble seed) and 0x41 (data scramble seed) are writable in both modes and drive `ram_addr_seed` and `ram_data_seed` from the cycle after the write; reading them returns zero.
- R9: Reads of unmapped addresses return zero, and writes to unmapped addresses change no output and no readable register.
- R10: `rdata` is registered. A read at edge k shows its value after edge k, and after any edge without a read `rdata` is zero.
- R11: While `rst_n` is low at a clock edge, all writable registers, `rdata` and the synchronizer clear, and the device returns to firmware mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Bus access strobe for this cycle |
| we | input | 1 | 1 = write, 0 = read (when cs is high) |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| app_mode | output | 1 | 1 once the device is in application mode |
| led | output | 3 | LED drive: [0] blue, [1] green, [2] red |
| gpio_in | input | 2 | Asynchronous general-purpose inputs |
| gpio_out | output | 2 | General-purpose output levels |
| ram_addr_seed | output | 32 | RAM address scrambling seed |
| ram_data_seed | output | 32 | RAM data scrambling seed |

## Verification
Writes land at the clock edge that samples them, so the LED, GPIO output, seed and mode ports are due one edge after the write. Read data is due one edge after the read. A GPIO input level needs two edges of synchronizer before a read can capture it, so it appears on `rdata` after the third edge. The bench drives the bus and inputs on the falling edge. A behavioural model updates at the same rising edge as the design, keeping a two-entry queue for the input pins. Every port is compared against the model on the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam logic [7:0] A_NAME0     = 8'h00;
  localparam logic [7:0] A_NAME1     = 8'h01;
  localparam logic [7:0] A_VERSION   = 8'h02;
  localparam logic [7:0] A_MODE      = 8'h08;
  localparam logic [7:0] A_LED       = 8'h09;
  localparam logic [7:0] A_GPIO      = 8'h0a;
  localparam logic [7:0] A_APP_START = 8'h0c;
  localparam logic [7:0] A_APP_SIZE  = 8'h0d;
  localparam logic [7:0] A_FN_PTR    = 8'h10;
  localparam logic [7:0] A_SECRET    = 8'h20;
  localparam logic [7:0] A_UID_HI    = 8'h30;
  localparam logic [7:0] A_UID_LO    = 8'h31;
  localparam logic [7:0] A_SEED_ADDR = 8'h40;
  localparam logic [7:0] A_SEED_DATA = 8'h41;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [7:0]  addr;
    logic [31:0] data;
  } bus_req_t;
endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sdc_mode_lock.sv
module sdc_mode_lock
  import sdc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_req_t req,
  output logic     app_mode
);
  logic mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_q <= 1'b0;
    else if (req.wr && req.addr == A_MODE && !mode_q)
      mode_q <= 1'b1;
  end

  assign app_mode = mode_q;

  // R2: once set, application mode holds until reset
  a_r2_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    app_mode |=> app_mode);

  // R2: a mode-switch write in firmware mode enters application mode
  a_r2_mode_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (req.wr && req.addr == A_MODE) |=> app_mode);
endmodule

// File: rtl/sdc_regs.sv
module sdc_regs
  import sdc_pkg::*;
#(
  parameter int SECRET_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  bus_req_t                      req,
  input  logic                          locked,
  output logic [2:0]                    led,
  output logic [1:0]                    gpio_out,
  output logic [31:0]                   app_start,
  output logic [31:0]                   app_size,
  output logic [31:0]                   fn_ptr,
  output logic [SECRET_WORDS-1:0][31:0] secret,
  output logic [31:0]                   seed_addr,
  output logic [31:0]                   seed_data
);
  logic wr_open;
  assign wr_open = req.wr && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led       <= '0;
      gpio_out  <= '0;
      seed_addr <= '0;
      seed_data <= '0;
    end else if (req.wr) begin
      if (req.addr == A_LED)       led       <= req.data[2:0];
      if (req.addr == A_GPIO)      gpio_out  <= req.data[3:2];
      if (req.addr == A_SEED_ADDR) seed_addr <= req.data;
      if (req.addr == A_SEED_DATA) seed_data <= req.data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      app_start <= '0;
      app_size  <= '0;
      fn_ptr    <= '0;
    end else if (wr_open) begin
      if (req.addr == A_APP_START) app_start <= req.data;
      if (req.addr == A_APP_SIZE)  app_size  <= req.data;
      if (req.addr == A_FN_PTR)    fn_ptr    <= req.data;
    end
  end

  for (genvar i = 0; i < SECRET_WORDS; i++) begin : g_secret
    always_ff @(posedge clk) begin
      if (!rst_n)
        secret[i] <= '0;
      else if (wr_open && req.addr == 8'(A_SECRET + i))
        secret[i] <= req.data;
    end
  end

  // R5: locked introspection registers stay frozen
  a_r5_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(app_start) && $stable(app_size) && $stable(fn_ptr)));

  // R6: locked secret stays frozen
  a_r6_secret_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(secret));

  // R3: LED follows the written bits
  a_r3_led_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req.wr && req.addr == A_LED) |=> led == $past(req.data[2:0]));
endmodule

// File: rtl/secure_ctrl_regs.sv
module secure_ctrl_regs
  import sdc_pkg::*;
#(
  parameter logic [31:0] NAME0        = 32'h746f6b6e,
  parameter logic [31:0] NAME1        = 32'h63746c31,
  parameter logic [31:0] VERSION      = 32'h00000003,
  parameter logic [63:0] UID          = 64'h0123_4567_89ab_cdef,
  parameter int          SECRET_WORDS = 8,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs,
  input  logic        we,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        app_mode,
  output logic [2:0]  led,
  input  logic [1:0]  gpio_in,
  output logic [1:0]  gpio_out,
  output logic [31:0] ram_addr_seed,
  output logic [31:0] ram_data_seed
);
  localparam int IDX_W = (SECRET_WORDS > 1) ? $clog2(SECRET_WORDS) : 1;

  bus_req_t req;
  assign req.wr   = cs && we;
  assign req.rd   = cs && !we;
  assign req.addr = addr;
  assign req.data = wdata;

  logic [1:0]                    gpio_sync;
  logic [31:0]                   app_start, app_size, fn_ptr;
  logic [SECRET_WORDS-1:0][31:0] secret;

  sdc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(gpio_sync)
  );

  sdc_mode_lock u_mode (
    .clk(clk), .rst_n(rst_n), .req(req), .app_mode(app_mode)
  );

  sdc_regs #(.SECRET_WORDS(SECRET_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .req(req), .locked(app_mode),
    .led(led), .gpio_out(gpio_out),
    .app_start(app_start), .app_size(app_size), .fn_ptr(fn_ptr),
    .secret(secret),
    .seed_addr(ram_addr_seed), .seed_data(ram_data_seed)
  );

  logic [7:0]       sec_off;
  logic             sec_hit;
  logic [IDX_W-1:0] sec_idx;
  logic [31:0]      rd_mux;

  assign sec_off = addr - A_SECRET;
  assign sec_hit = ({24'd0, sec_off} < 32'(SECRET_WORDS));
  assign sec_idx = IDX_W'(sec_off);

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_NAME0:     rd_mux = NAME0;
      A_NAME1:     rd_mux = NAME1;
      A_VERSION:   rd_mux = VERSION;
      A_MODE:      rd_mux = {31'd0, app_mode};
      A_LED:       rd_mux = {29'd0, led};
      A_GPIO:      rd_mux = {28'd0, gpio_out, gpio_sync};
      A_APP_START: rd_mux = app_start;
      A_APP_SIZE:  rd_mux = app_size;
      A_FN_PTR:    rd_mux = fn_ptr;
      A_UID_HI:    rd_mux = UID[63:32];
      A_UID_LO:    rd_mux = UID[31:0];
      default:     if (sec_hit) rd_mux = secret[sec_idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= '0;
    else if (req.rd) rdata <= rd_mux;
    else             rdata <= '0;
  end

  // R10: no read, no data
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !req.rd |=> rdata == '0);

  // R8: seed registers never appear on the bus
  a_r8_seed_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (req.rd && (addr == A_SEED_ADDR || addr == A_SEED_DATA)) |=> rdata == '0);

  // R4: output pins follow a GPIO write
  a_r4_gpio_out: assert property (@(posedge clk) disable iff (!rst_n)
    (req.wr && addr == A_GPIO) |=> gpio_out == $past(wdata[3:2]));
endmodule

// File: tb/tb_secure_ctrl_regs.sv
module tb_secure_ctrl_regs;
  localparam logic [31:0] N0 = 32'h746f6b6e;
  localparam logic [31:0] N1 = 32'h63746c31;
  localparam logic [31:0] VER = 32'h00000003;
  localparam logic [63:0] UIDV = 64'h0123_4567_89ab_cdef;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0] gpio_in = '0;
  logic [31:0] rdata, ram_addr_seed, ram_data_seed;
  logic app_mode;
  logic [2:0] led;
  logic [1:0] gpio_out;

  always #2.5 clk = ~clk;

  secure_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .app_mode(app_mode), .led(led), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .ram_addr_seed(ram_addr_seed), .ram_data_seed(ram_data_seed)
  );

  int checks = 0;
  int failures = 0;
  bit compare_on = 1'b0;

  // behavioural model state
  bit        m_mode;
  bit [2:0]  m_led;
  bit [1:0]  m_gout;
  bit [31:0] m_start, m_size, m_ptr, m_sa, m_sd, m_rdata;
  bit [31:0] m_sec [8];
  bit [1:0]  m_pins [$];
  string     m_tag = "R11";

  function automatic string tag_of(input logic [7:0] a);
    if (a <= 8'h02) return "R1";
    if (a == 8'h08) return "R2";
    if (a == 8'h09) return "R3";
    if (a == 8'h0a) return "R4";
    if (a == 8'h0c || a == 8'h0d || a == 8'h10) return "R5";
    if (a >= 8'h20 && a <= 8'h27) return "R6";
    if (a == 8'h30 || a == 8'h31) return "R7";
    if (a == 8'h40 || a == 8'h41) return "R8";
    return "R9";
  endfunction

  function automatic bit [31:0] model_read(input logic [7:0] a);
    bit [1:0] pins = m_pins[0];
    case (a)
      8'h00: return N0;
      8'h01: return N1;
      8'h02: return VER;
      8'h08: return {31'd0, m_mode};
      8'h09: return {29'd0, m_led};
      8'h0a: return {28'd0, m_gout, pins};
      8'h0c: return m_start;
      8'h0d: return m_size;
      8'h10: return m_ptr;
      8'h30: return UIDV[63:32];
      8'h31: return UIDV[31:0];
      default: if (a >= 8'h20 && a <= 8'h27) return m_sec[a - 8'h20];
    endcase
    return 32'd0;
  endfunction

  initial begin
    m_pins.push_back(2'b00);
    m_pins.push_back(2'b00);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_led = 0; m_gout = 0; m_start = 0; m_size = 0; m_ptr = 0;
      m_sa = 0; m_sd = 0; m_rdata = 0;
      foreach (m_sec[i]) m_sec[i] = 0;
      m_pins = {2'b00, 2'b00};
      m_tag = "R11";
    end else begin
      m_tag = (cs && !we) ? tag_of(addr) : "R10";
      m_rdata = (cs && !we) ? model_read(addr) : 32'd0;
      if (cs && we) begin
        m_tag = tag_of(addr);
        case (addr)
          8'h08: m_mode = 1;
          8'h09: m_led = wdata[2:0];
          8'h0a: m_gout = wdata[3:2];
          8'h40: m_sa = wdata;
          8'h41: m_sd = wdata;
          default: ;
        endcase
        if (!m_mode || addr == 8'h08) begin
          // locked registers are judged against the mode before this edge
        end
      end
      m_pins.pop_front();
      m_pins.push_back(gpio_in);
    end
  end

  // locked-register writes use the pre-edge mode, so apply them separately
  bit pre_mode;
  always @(negedge clk) pre_mode = m_mode;
  always @(posedge clk) begin
    if (rst_n && cs && we && !pre_mode) begin
      case (addr)
        8'h0c: m_start = wdata;
        8'h0d: m_size = wdata;
        8'h10: m_ptr = wdata;
        default: if (addr >= 8'h20 && addr <= 8'h27) m_sec[addr - 8'h20] = wdata;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      chk(m_tag, "rdata", rdata, m_rdata);
      chk("R2", "app_mode", {31'd0, app_mode}, {31'd0, m_mode});
      chk("R3", "led", {29'd0, led}, {29'd0, m_led});
      chk("R4", "gpio_out", {30'd0, gpio_out}, {30'd0, m_gout});
      chk("R8", "ram_addr_seed", ram_addr_seed, m_sa);
      chk("R8", "ram_data_seed", ram_data_seed, m_sd);
    end
  end

  task automatic idle();
    @(negedge clk); cs = 0; we = 0;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
  endtask
  task automatic rd(input logic [7:0] a);
    @(negedge clk); cs = 1; we = 0; addr = a; wdata = 32'hdead_beef;
  endtask
  task automatic rd_all();
    foreach (amap[i]) rd(amap[i]);
  endtask

  logic [7:0] amap [24] = '{8'h00, 8'h01, 8'h02, 8'h08, 8'h09, 8'h0a, 8'h0c, 8'h0d,
                             8'h10, 8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26,
                             8'h27, 8'h30, 8'h31, 8'h40, 8'h41, 8'h05, 8'h50, 8'hff};

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare_on = 1;
    // R11 reset state read-out
    rd_all(); idle();
    // R1 / R7 identity writes ignored
    wr(8'h00, 32'h1111_1111); wr(8'h02, 32'h2); wr(8'h30, 32'h3); wr(8'h31, 32'h4);
    rd(8'h00); rd(8'h02); rd(8'h30); rd(8'h31);
    // R3 LED patterns
    for (int i = 0; i < 8; i++) begin wr(8'h09, 32'hffff_fff8 | i); rd(8'h09); end
    // R4 GPIO inputs and outputs
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); gpio_in = 2'(i); cs = 0;
      rd(8'h0a); rd(8'h0a); rd(8'h0a); rd(8'h0a);
      wr(8'h0a, {28'd0, 2'(3 - i), 2'(i)}); rd(8'h0a);
    end
    // R5 / R6 / R8 firmware provisioning
    wr(8'h0c, 32'h0004_0000); wr(8'h0d, 32'h0000_1234); wr(8'h10, 32'h0000_0abc);
    for (int i = 0; i < 8; i++) wr(8'(8'h20 + i), 32'hc0de_0000 + 32'(i * 7));
    wr(8'h40, 32'h5a5a_1234); wr(8'h41, 32'ha5a5_4321);
    // R9 unmapped writes
    wr(8'h05, 32'hffff_ffff); wr(8'h50, 32'hffff_ffff); wr(8'h28, 32'hffff_ffff);
    rd_all();
    // R2 mode switch
    rd(8'h08); wr(8'h08, 32'h0); rd(8'h08);
    // locked writes refused, open writes still work
    wr(8'h0c, 32'h1); wr(8'h0d, 32'h2); wr(8'h10, 32'h3);
    for (int i = 0; i < 8; i++) wr(8'(8'h20 + i), 32'hffff_0000);
    wr(8'h09, 32'h5); wr(8'h0a, 32'hc); wr(8'h40, 32'h77); wr(8'h41, 32'h88);
    wr(8'h08, 32'h1);
    rd_all(); idle();
    // R11 reset returns to firmware mode
    @(negedge clk); cs = 0; rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd_all();
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 99);
      gpio_in = 2'($urandom);
      if (r < 45) rd(amap[$urandom_range(0, 23)]);
      else if (r < 90) wr(amap[$urandom_range(0, 23)], $urandom);
      else if (r < 93) wr(8'h08, 32'h0);
      else if (r < 95) begin @(negedge clk); cs = 0; rst_n = 0; @(negedge clk); rst_n = 1; end
      else idle();
    end
    idle(); idle();
    compare_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule